// File: doc/BRIEF.md
# Random-Delay Reaction Timer

This block runs a reaction-time game. After reset it is idle and asks the display to show a greeting. When the player presses start, it takes a value from a free-running pseudo-random generator and turns it into a wait of between one and about four seconds. It counts that wait in milliseconds and then lights the LED. From that moment it counts the player's reaction time in milliseconds until the stop button is pressed.

If stop is pressed while the LED is still dark, the round counts as a false start and an error code is shown. A finished or fouled round is held until the next reset. The start and stop inputs are single-cycle pulses that have already been debounced. Decoding the display mode and the elapsed time into segments is done outside this block.

Top module: `reaction_timer`

## Requirements
- R1: After reset the block is idle: `disp_mode_o` is 0 (greeting), `led_o` is 0 and `elapsed_ms_o` is 0.
- R2: A stop pulse while idle has no effect: the display mode stays 0 and the LED stays off.
- R3: A start pulse while idle begins the wait phase: `disp_mode_o` becomes 1 and the LED stays off.
- R4: The LED lights exactly `1000 + floor(3*r/4)` ms after the start pulse is accepted, so the wait always lies between 1000 and 4071 ms. Here r is the low 12 bits of a 16-bit LFSR that steps every clock from a nonzero seed and never holds zero.
- R5: When the LED lights, `disp_mode_o` becomes 2 and `elapsed_ms_o` restarts from 0. It then shows the whole milliseconds elapsed since the LED came on.
- R6: A stop pulse while the LED is lit turns the LED off and freezes `elapsed_ms_o`. The frozen value is the whole milliseconds elapsed before the clock edge that samples the stop. It is held until reset.
- R7: A start pulse outside the idle state is ignored. It neither restarts the timer nor changes a held result or error.
- R8: A stop pulse during the wait phase is a false start. `disp_mode_o` becomes 3, `elapsed_ms_o` is 0, and the LED never lights until reset.
- R9: The reaction time saturates at 9999 ms and never exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Debounced start pulse |
| stop_i | input | 1 | Debounced stop pulse |
| led_o | output | 1 | Go LED, lit while the reaction is being timed |
| disp_mode_o | output | 2 | 0 greeting, 1 waiting, 2 time, 3 false-start error |
| elapsed_ms_o | output | 14 | Reaction time in milliseconds |

## Verification
The saturation case is the hardest to reach from the ports, because the player must stay silent for ten thousand milliseconds after a random wait. The bench shrinks the millisecond prescaler to two clocks so that this takes about twenty thousand cycles. Because the random target cannot be seen at the ports, the bench measures the cycles from start to LED. It checks that this count is a whole number of milliseconds and lies inside the allowed window. It then times stop pulses relative to the observed LED edge, so each frozen value can be predicted exactly.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN,
    ST_DONE,
    ST_FOUL
  } rt_state_e;

  typedef enum logic [1:0] {
    DISP_HI   = 2'd0,
    DISP_WAIT = 2'd1,
    DISP_TIME = 2'd2,
    DISP_FOUL = 2'd3
  } disp_e;

  // One step of a 16-bit Fibonacci LFSR, taps 16,14,13,11
  function automatic logic [15:0] lfsr_step(input logic [15:0] q);
    logic fb;
    fb = q[15] ^ q[13] ^ q[12] ^ q[10];
    return {q[14:0], fb};
  endfunction

  // Wait length in ms: base plus three quarters of the masked random value
  function automatic int unsigned wait_ms(input logic [15:0] r,
                                          input int unsigned base_ms,
                                          input int unsigned span_bits);
    int unsigned masked;
    masked = 32'(r) & ((32'd1 << span_bits) - 32'd1);
    return base_ms + ((masked * 32'd3) >> 2);
  endfunction

endpackage

// File: rtl/rt_lfsr.sv
module rt_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] q_o
);
  import rt_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= SEED;
    else        q_o <= lfsr_step(q_o);
  end

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_o != 16'd0);
endmodule

// File: rtl/rt_ms_tick.sv
module rt_ms_tick #(
  parameter int TICKS_PER_MS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MS - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == LAST) && !clr_i;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/rt_ms_count.sv
module rt_ms_count #(
  parameter int CW     = 14,
  parameter int MAX_MS = 9999
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          hold_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = CW'(MAX_MS);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_o <= '0;
    else if (tick_i && !hold_i && cnt_o != CMAX) cnt_o <= cnt_o + 1'b1;
  end

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= CMAX);
endmodule

// File: rtl/reaction_timer.sv
module reaction_timer #(
  parameter int          TICKS_PER_MS = 250000,
  parameter int          BASE_MS      = 1000,
  parameter int          SPAN_BITS    = 12,
  parameter int          MAX_MS       = 9999,
  parameter logic [15:0] SEED         = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        stop_i,
  output logic        led_o,
  output logic [1:0]  disp_mode_o,
  output logic [13:0] elapsed_ms_o
);
  import rt_pkg::*;

  localparam int CW = 14;
  localparam int WAIT_MAX = BASE_MS + ((((1 << SPAN_BITS) - 1) * 3) >> 2);

  rt_state_e      state_q;
  logic [15:0]    rnd;
  logic [CW-1:0]  target_q;
  logic [CW-1:0]  cnt;
  logic           tick;

  // Named internal events
  logic start_accept, wait_done, foul_evt, stop_evt, cnt_clr, cnt_hold;

  assign start_accept = (state_q == ST_IDLE) && start_i;
  assign wait_done    = (state_q == ST_WAIT) && (cnt == target_q);
  assign foul_evt     = (state_q == ST_WAIT) && stop_i;
  assign stop_evt     = (state_q == ST_RUN) && stop_i;
  assign cnt_clr      = start_accept || (wait_done && !stop_i);
  assign cnt_hold     = stop_i || !((state_q == ST_WAIT) || (state_q == ST_RUN));

  rt_lfsr #(.SEED(SEED)) lfsr_i (
    .clk(clk), .rst_n(rst_n), .q_o(rnd)
  );

  rt_ms_tick #(.TICKS_PER_MS(TICKS_PER_MS)) tick_i (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .tick_o(tick)
  );

  rt_ms_count #(.CW(CW), .MAX_MS(MAX_MS)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .hold_i(cnt_hold),
    .tick_i(tick), .cnt_o(cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_WAIT;
          target_q <= CW'(wait_ms(rnd, BASE_MS, SPAN_BITS));
        end
        ST_WAIT: begin
          if (foul_evt)       state_q <= ST_FOUL;
          else if (wait_done) state_q <= ST_RUN;
        end
        ST_RUN:  if (stop_evt) state_q <= ST_DONE;
        default: state_q <= state_q;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_IDLE:          disp_mode_o = DISP_HI;
      ST_WAIT:          disp_mode_o = DISP_WAIT;
      ST_RUN, ST_DONE:  disp_mode_o = DISP_TIME;
      default:          disp_mode_o = DISP_FOUL;
    endcase
  end

  assign led_o        = (state_q == ST_RUN);
  assign elapsed_ms_o = ((state_q == ST_RUN) || (state_q == ST_DONE)) ? cnt : '0;

  // R4
  target_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (target_q >= CW'(BASE_MS) && target_q <= CW'(WAIT_MAX)));

  // R5
  led_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led_o) |-> $past(wait_done));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && $past(state_q == ST_DONE)) |-> $stable(elapsed_ms_o));

  // R8
  foul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    foul_evt |=> (disp_mode_o == 2'd3 && !led_o));

  // R2
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE));
endmodule

// File: tb/reaction_timer_tb.sv
module reaction_timer_tb_top;
  localparam int T = 2;
  localparam int BASE = 1000;
  localparam int WMAX = 4071;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic stop_i = 1'b0;
  logic led_o;
  logic [1:0] disp_mode_o;
  logic [13:0] elapsed_ms_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  reaction_timer #(.TICKS_PER_MS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .led_o(led_o), .disp_mode_o(disp_mode_o), .elapsed_ms_o(elapsed_ms_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
  endtask

  // Press start, wait for the LED; checks the wait length (R3, R4)
  task automatic start_and_wait();
    int n;
    start_i = 1'b1;
    n = 0;
    @(negedge clk); n++;
    start_i = 1'b0;
    chk("R3 disp waiting", int'(disp_mode_o), 1);
    chk("R3 led off", int'(led_o), 0);
    while (!led_o && n < 20000) begin
      @(negedge clk); n++;
    end
    chk("R4 led lit", int'(led_o), 1);
    chk("R4 whole ms", (n - 2) % T, 0);
    chk("R4 wait in window", int'(((n - 2) / T) >= BASE && ((n - 2) / T) <= WMAX), 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 disp", int'(disp_mode_o), 0);
    chk("R1 led", int'(led_o), 0);
    chk("R1 elapsed", int'(elapsed_ms_o), 0);
  endtask

  task automatic t_idle_stop();
    do_reset();
    pulse_stop();
    repeat (5) @(negedge clk);
    chk("R2 disp", int'(disp_mode_o), 0);
    chk("R2 led", int'(led_o), 0);
  endtask

  task automatic t_normal(input int skew, input int n_cyc);
    do_reset();
    repeat (skew) @(negedge clk);
    start_and_wait();
    chk("R5 disp time", int'(disp_mode_o), 2);
    chk("R5 elapsed zero", int'(elapsed_ms_o), 0);
    repeat (201) @(negedge clk);
    chk("R5 mid count", int'(elapsed_ms_o), 201 / T);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;   // R7 ignored in run
    repeat (n_cyc - 202) @(negedge clk);
    pulse_stop();
    chk("R6 led off", int'(led_o), 0);
    chk("R6 frozen", int'(elapsed_ms_o), n_cyc / T);
    repeat (60) @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    chk("R7 held after start", int'(elapsed_ms_o), n_cyc / T);
    chk("R7 led stays off", int'(led_o), 0);
    chk("R6 disp time", int'(disp_mode_o), 2);
  endtask

  task automatic t_foul();
    do_reset();
    repeat (7) @(negedge clk);
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_stop();
    chk("R8 disp error", int'(disp_mode_o), 3);
    chk("R8 elapsed", int'(elapsed_ms_o), 0);
    repeat (9000) @(negedge clk);
    chk("R8 led never", int'(led_o), 0);
    pulse_start();
    repeat (5) @(negedge clk);
    chk("R7 error held", int'(disp_mode_o), 3);
  endtask

  task automatic t_saturate();
    do_reset();
    start_and_wait();
    repeat (21000) @(negedge clk);
    chk("R9 saturated", int'(elapsed_ms_o), 9999);
    chk("R9 led on", int'(led_o), 1);
    pulse_stop();
    chk("R9 frozen at max", int'(elapsed_ms_o), 9999);
  endtask

  initial begin
    t_reset();
    t_idle_stop();
    t_normal(0, 1600);
    t_normal(13, 1603);
    t_foul();
    t_saturate();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(190000 * 4);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule